// File: doc/BRIEF.md
# Multi-Mode Chip Reset Sequencer

This block steps a chip through its internal reset after power-up or after a later reset request. Five kinds of reset are supported, picked by a 3-bit class code that arrives with a one-cycle trigger. Each kind follows its own path through these stages:

- oscillator and power setup
- flash initialisation
- device configuration
- an optional self-test (setup, memory test, logic test)

When the self-test runs, flash initialisation and configuration are repeated before the chip is released. Each stage is started by a one-cycle strobe, and the block then waits for that stage's done strobe. A cycle counter catches a stage that never reports done. On timeout it sets a sticky error flag and restarts from oscillator and power setup.

The chip reset pin is open-drain. The block only enables a low drive on it, and a high level can come only from an external pull-up. The drive is released when the last configuration stage finishes. The block then waits until the pin, passed through a two-flop synchroniser, reads high. An external reset source can therefore stretch the sequence for as long as it likes, and that wait is not timed. After the wait the block enters run mode: it gives one start pulse and then holds a steady run flag.

Top module: `reset_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the reset pin drive is enabled, the power-setup start strobe is high, the run flag is low and the error flag is low.
- R2: Class codes 0 and 2, and the unused codes 5 to 7, start these stages in this order: power, flash, configuration, self-test setup, memory test, logic test, flash, configuration, then run. Self-test setup lasts exactly one cycle.
- R3: Class code 1 starts power, flash and configuration, then run.
- R4: Class code 3 starts flash and configuration, then run.
- R5: Class code 4 starts only configuration, then run.
- R6: The pin drive stays enabled from reset or trigger until the last configuration done strobe. It is released in the cycle after that strobe and stays released while the block waits for the pin or is in run mode.
- R7: Run mode begins on the third rising clock edge after the pin input goes high. While the pin reads low, run mode is not entered.
- R8: The wait for the pin is not timed: it may last longer than the stage timeout without raising the error flag.
- R9: run_start is high for exactly one cycle when run mode is entered, and run_mode then stays high until the next trigger.
- R10: If a stage gets no done strobe, the power-setup start strobe appears exactly TIMEOUT_CYC cycles after that stage's start strobe. At the same time the error flag rises, and it stays set until power-on reset.
- R11: A trigger arriving in any state abandons the current path and restarts at the first stage of the new class. Done strobes for stages that are not active have no effect.
- R12: At most one start strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| trig_valid | input | 1 | One-cycle reset request |
| trig_class | input | 3 | Reset class code, sampled with trig_valid |
| pin_in | input | 1 | Level read back from the reset pin |
| pwr_done | input | 1 | Power/oscillator stage finished |
| flash_done | input | 1 | Flash initialisation finished |
| cfg_done | input | 1 | Device configuration finished |
| mbist_done | input | 1 | Memory self-test finished |
| lbist_done | input | 1 | Logic self-test finished |
| pin_drive_low | output | 1 | Enables the open-drain low drive on the reset pin |
| pwr_start | output | 1 | Start strobe, power/oscillator stage |
| flash_start | output | 1 | Start strobe, flash initialisation |
| cfg_start | output | 1 | Start strobe, device configuration |
| st_setup_start | output | 1 | Strobe for the one-cycle self-test setup |
| mbist_start | output | 1 | Start strobe, memory self-test |
| lbist_start | output | 1 | Start strobe, logic self-test |
| run_start | output | 1 | One-cycle pulse on entry to run mode |
| run_mode | output | 1 | Steady flag: run mode active |
| timeout_err | output | 1 | Sticky stage timeout flag |

## Verification
The assertions assume that the pin input can read high only while the block has its drive released. They also assume that trig_valid is a single-cycle pulse and that done strobes are single cycles. The bench models the pin as the block's own drive combined with an external holder, so the first assumption always holds. The bench drives trigger and done strobes for one cycle only, away from the clock edge. Done strobes are sent only after the matching start has been seen, but a restarted sequence can leave a pending strobe that arrives while a different stage is active. That case is exercised on purpose to show that such strobes are ignored.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_PWR     = 3'd0,
        ST_FLASH   = 3'd1,
        ST_CFG     = 3'd2,
        ST_SETUP   = 3'd3,
        ST_MBIST   = 3'd4,
        ST_LBIST   = 3'd5,
        ST_RELEASE = 3'd6,
        ST_RUN     = 3'd7
    } seq_state_e;

    localparam logic [2:0] CLS_DESTR_BIST  = 3'd0;
    localparam logic [2:0] CLS_DESTR_PLAIN = 3'd1;
    localparam logic [2:0] CLS_EXT_LONG    = 3'd2;
    localparam logic [2:0] CLS_FUNC_LONG   = 3'd3;
    localparam logic [2:0] CLS_FUNC_SHORT  = 3'd4;

    typedef struct packed {
        seq_state_e state;
        logic       bist;    // path includes self-test
        logic       second;  // self-test already done on this path
        logic       fresh;   // first cycle in current state
        logic       err;     // sticky timeout flag
    } seq_regs_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b0;
                else        chain_q <= d_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[LAST];
endmodule

// File: rtl/rstseq_phase_timer.sv
module rstseq_phase_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rstseq_route.sv
module rstseq_route
    import rstseq_pkg::*;
(
    input  logic [2:0]  trig_class,
    input  seq_state_e  cur_state,
    input  logic        cur_bist,
    input  logic        cur_second,
    output seq_state_e  entry_state,
    output logic        entry_bist,
    output seq_state_e  after_state,
    output logic        after_second
);
    // first stage and self-test choice of a newly requested class
    always_comb begin
        unique case (trig_class)
            CLS_DESTR_PLAIN: begin entry_state = ST_PWR;   entry_bist = 1'b0; end
            CLS_EXT_LONG:    begin entry_state = ST_PWR;   entry_bist = 1'b1; end
            CLS_FUNC_LONG:   begin entry_state = ST_FLASH; entry_bist = 1'b0; end
            CLS_FUNC_SHORT:  begin entry_state = ST_CFG;   entry_bist = 1'b0; end
            default:         begin entry_state = ST_PWR;   entry_bist = 1'b1; end
        endcase
    end

    // successor of the current stage once it completes
    always_comb begin
        after_second = cur_second;
        unique case (cur_state)
            ST_PWR:     after_state = ST_FLASH;
            ST_FLASH:   after_state = ST_CFG;
            ST_CFG:     after_state = (cur_bist && !cur_second) ? ST_SETUP : ST_RELEASE;
            ST_SETUP:   after_state = ST_MBIST;
            ST_MBIST:   after_state = ST_LBIST;
            ST_LBIST: begin
                after_state  = ST_FLASH;
                after_second = 1'b1;
            end
            ST_RELEASE: after_state = ST_RUN;
            default:    after_state = ST_RUN;
        endcase
    end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_valid,
    input  logic [2:0] trig_class,
    input  logic       pin_in,
    input  logic       pwr_done,
    input  logic       flash_done,
    input  logic       cfg_done,
    input  logic       mbist_done,
    input  logic       lbist_done,
    output logic       pin_drive_low,
    output logic       pwr_start,
    output logic       flash_start,
    output logic       cfg_start,
    output logic       st_setup_start,
    output logic       mbist_start,
    output logic       lbist_start,
    output logic       run_start,
    output logic       run_mode,
    output logic       timeout_err
);
    localparam seq_regs_t RESET_VAL = '{state: ST_PWR, bist: 1'b1, second: 1'b0,
                                        fresh: 1'b1, err: 1'b0};

    seq_regs_t  cur_q, nxt_d;
    logic       pin_hi;
    logic       stage_done;
    logic       waiting;
    logic       expired;
    seq_state_e entry_state, after_state;
    logic       entry_bist, after_second;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_hi)
    );

    rstseq_route u_route (
        .trig_class   (trig_class),
        .cur_state    (cur_q.state),
        .cur_bist     (cur_q.bist),
        .cur_second   (cur_q.second),
        .entry_state  (entry_state),
        .entry_bist   (entry_bist),
        .after_state  (after_state),
        .after_second (after_second)
    );

    // stages that wait on an external done strobe are the timed ones
    always_comb begin
        unique case (cur_q.state)
            ST_PWR:     begin stage_done = pwr_done;   waiting = 1'b1; end
            ST_FLASH:   begin stage_done = flash_done; waiting = 1'b1; end
            ST_CFG:     begin stage_done = cfg_done;   waiting = 1'b1; end
            ST_SETUP:   begin stage_done = 1'b1;       waiting = 1'b0; end
            ST_MBIST:   begin stage_done = mbist_done; waiting = 1'b1; end
            ST_LBIST:   begin stage_done = lbist_done; waiting = 1'b1; end
            ST_RELEASE: begin stage_done = pin_hi;     waiting = 1'b0; end
            default:    begin stage_done = 1'b0;       waiting = 1'b0; end
        endcase
    end

    rstseq_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (nxt_d.fresh),
        .run     (waiting),
        .expired (expired)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.fresh = 1'b0;
        if (trig_valid) begin
            nxt_d.state  = entry_state;
            nxt_d.bist   = entry_bist;
            nxt_d.second = 1'b0;
            nxt_d.fresh  = 1'b1;
        end else if (stage_done) begin
            nxt_d.state  = after_state;
            nxt_d.second = after_second;
            nxt_d.fresh  = 1'b1;
        end else if (expired) begin
            nxt_d.state  = ST_PWR;
            nxt_d.second = 1'b0;
            nxt_d.fresh  = 1'b1;
            nxt_d.err    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RESET_VAL;
        else        cur_q <= nxt_d;
    end

    assign pin_drive_low  = (cur_q.state != ST_RELEASE) && (cur_q.state != ST_RUN);
    assign pwr_start      = cur_q.fresh && (cur_q.state == ST_PWR);
    assign flash_start    = cur_q.fresh && (cur_q.state == ST_FLASH);
    assign cfg_start      = cur_q.fresh && (cur_q.state == ST_CFG);
    assign st_setup_start = cur_q.fresh && (cur_q.state == ST_SETUP);
    assign mbist_start    = cur_q.fresh && (cur_q.state == ST_MBIST);
    assign lbist_start    = cur_q.fresh && (cur_q.state == ST_LBIST);
    assign run_start      = cur_q.fresh && (cur_q.state == ST_RUN);
    assign run_mode       = (cur_q.state == ST_RUN);
    assign timeout_err    = cur_q.err;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_valid,
    input logic cfg_done,
    input logic pin_hi,
    input logic pin_drive_low,
    input logic pwr_start,
    input logic flash_start,
    input logic cfg_start,
    input logic st_setup_start,
    input logic mbist_start,
    input logic lbist_start,
    input logic run_start,
    input logic run_mode,
    input logic timeout_err
);
    AST_RUN_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |-> !pin_drive_low);                                       // R6

    AST_RELEASE_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_drive_low) |-> ($past(cfg_done) && !$past(trig_valid)));  // R6

    AST_RUN_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !$past(run_mode)) |-> $past(pin_hi));                 // R7

    AST_RUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !trig_valid) |=> (!run_start && run_mode));           // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);                                       // R10

    AST_ERR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> pwr_start);                                  // R10

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwr_start, flash_start, cfg_start, st_setup_start,
                  mbist_start, lbist_start, run_start}));                   // R12

    AST_SETUP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_setup_start && !trig_valid) |=> mbist_start);                   // R2
endmodule

bind reset_sequencer rstseq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_valid     (trig_valid),
    .cfg_done       (cfg_done),
    .pin_hi         (pin_hi),
    .pin_drive_low  (pin_drive_low),
    .pwr_start      (pwr_start),
    .flash_start    (flash_start),
    .cfg_start      (cfg_start),
    .st_setup_start (st_setup_start),
    .mbist_start    (mbist_start),
    .lbist_start    (lbist_start),
    .run_start      (run_start),
    .run_mode       (run_mode),
    .timeout_err    (timeout_err)
);

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_valid = 1'b0;
    logic [2:0] trig_class = 3'd0;
    logic ext_hold = 1'b0;
    logic pin_in;
    logic pwr_done = 0, flash_done = 0, cfg_done = 0, mbist_done = 0, lbist_done = 0;
    logic pin_drive_low, pwr_start, flash_start, cfg_start, st_setup_start;
    logic mbist_start, lbist_start, run_start, run_mode, timeout_err;

    int n_checks = 0;
    int n_fail = 0;
    int seq_log[64];
    int seq_len = 0;
    logic block_flash = 1'b0;
    logic [6:0] pend = '0;
    int dly[7];

    always #10 clk = ~clk;

    assign pin_in = ~pin_drive_low & ~ext_hold;

    reset_sequencer #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_class(trig_class),
        .pin_in(pin_in), .pwr_done(pwr_done), .flash_done(flash_done),
        .cfg_done(cfg_done), .mbist_done(mbist_done), .lbist_done(lbist_done),
        .pin_drive_low(pin_drive_low), .pwr_start(pwr_start), .flash_start(flash_start),
        .cfg_start(cfg_start), .st_setup_start(st_setup_start), .mbist_start(mbist_start),
        .lbist_start(lbist_start), .run_start(run_start), .run_mode(run_mode),
        .timeout_err(timeout_err)
    );

    // stage codes: 1 pwr, 2 flash, 3 cfg, 4 setup, 5 mbist, 6 lbist, 7 run
    always @(negedge clk) begin
        logic [6:0] st;
        pwr_done <= 0; flash_done <= 0; cfg_done <= 0; mbist_done <= 0; lbist_done <= 0;
        st = {run_start, lbist_start, mbist_start, st_setup_start, cfg_start, flash_start, pwr_start};
        if (rst_n) begin
            for (int i = 0; i < 7; i++) begin
                if (st[i] && seq_len < 64) begin
                    seq_log[seq_len] = i + 1;
                    seq_len = seq_len + 1;
                end
            end
            for (int i = 0; i < 6; i++) begin
                if (pend[i]) begin
                    if (dly[i] == 0) begin
                        pend[i] = 1'b0;
                        case (i)
                            0: pwr_done <= 1;
                            1: flash_done <= 1;
                            2: cfg_done <= 1;
                            4: mbist_done <= 1;
                            5: lbist_done <= 1;
                            default: ;
                        endcase
                    end else dly[i] = dly[i] - 1;
                end
            end
            for (int i = 0; i < 6; i++) begin
                if (st[i] && i != 3 && !(i == 1 && block_flash)) begin
                    pend[i] = 1'b1;
                    dly[i] = int'($urandom % 5) + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int cls);
        case (cls)
            1: return 4;
            3: return 3;
            4: return 2;
            default: return 9;
        endcase
    endfunction

    function automatic int exp_code(input int cls, input int idx);
        int bist_path[9] = '{1, 2, 3, 4, 5, 6, 2, 3, 7};
        int plain[4] = '{1, 2, 3, 7};
        case (cls)
            1: return plain[idx];
            3: return plain[idx + 1];
            4: return plain[idx + 2];
            default: return bist_path[idx];
        endcase
    endfunction

    function automatic string req_of(input int cls);
        case (cls)
            1: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic fire(input int cls);
        @(negedge clk); #1;
        seq_len = 0;
        trig_valid = 1'b1;
        trig_class = cls[2:0];
        @(negedge clk); #1;
        trig_valid = 1'b0;
    endtask

    task automatic wait_run();
        int n = 0;
        while ((seq_len == 0 || seq_log[seq_len-1] != 7) && n < 2000) begin
            @(negedge clk); #2;
            n++;
        end
        check(n < 2000, "R9 run reached", n, 2000);
    endtask

    task automatic check_seq(input int cls, input string tag);
        check(seq_len == exp_len(cls), {tag, " sequence length"}, seq_len, exp_len(cls));
        for (int i = 0; i < exp_len(cls) && i < seq_len; i++)
            check(seq_log[i] == exp_code(cls, i), {tag, " stage order"}, seq_log[i], exp_code(cls, i));
    endtask

    task automatic after_run(input string tag);
        check(run_mode == 1'b1, {tag, " R9 run flag"}, run_mode, 1);
        check(pin_drive_low == 1'b0, {tag, " R6 pin released"}, pin_drive_low, 0);
        @(negedge clk); #2;
        check(run_start == 1'b0, "R9 start pulse single", run_start, 0);
        check(run_mode == 1'b1, "R9 run flag steady", run_mode, 1);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int n;
        int cls;
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pin_drive_low == 1, "R1 drive during reset", pin_drive_low, 1);
        check(pwr_start == 1, "R1 power start during reset", pwr_start, 1);
        check(run_mode == 0, "R1 run low", run_mode, 0);
        check(timeout_err == 0, "R1 error low", timeout_err, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        wait_run();
        check_seq(0, "R1 power-on path");
        after_run("R1");

        // directed classes, including unused codes
        for (int c = 0; c < 8; c++) begin
            fire(c);
            wait_run();
            check_seq(c, req_of(c));
            after_run(req_of(c));
        end

        // R11: restart mid-sequence, stale done strobes ignored
        fire(0);
        n = 0;
        while (!(seq_len > 0 && seq_log[seq_len-1] == 5) && n < 500) begin
            @(negedge clk); #2; n++;
        end
        fire(4);
        wait_run();
        check_seq(4, "R11");
        fire(1);
        n = 0;
        while (!(seq_len > 0 && seq_log[seq_len-1] == 2) && n < 500) begin
            @(negedge clk); #2; n++;
        end
        fire(3);
        wait_run();
        check_seq(3, "R11");

        // R6, R7, R8: external holder keeps pin low
        ext_hold = 1'b1;
        fire(1);
        @(negedge clk); #2;
        check(pin_drive_low == 1, "R6 drive during stages", pin_drive_low, 1);
        n = 0;
        while (pin_drive_low && n < 500) begin @(negedge clk); #2; n++; end
        check(seq_log[seq_len-1] == 3, "R6 release after last cfg", seq_log[seq_len-1], 3);
        repeat (TMO + 20) @(negedge clk);
        #2;
        check(run_mode == 0, "R7 no run while pin low", run_mode, 0);
        check(timeout_err == 0, "R8 pin wait untimed", timeout_err, 0);
        check(pin_drive_low == 0, "R6 stays released", pin_drive_low, 0);
        @(negedge clk); #1;
        ext_hold = 1'b0;
        @(negedge clk); #2;
        check(run_mode == 0, "R7 sync edge 1", run_mode, 0);
        @(negedge clk); #2;
        check(run_mode == 0, "R7 sync edge 2", run_mode, 0);
        @(negedge clk); #2;
        check(run_mode == 1, "R7 run on third edge", run_mode, 1);
        check(run_start == 1, "R9 start with run entry", run_start, 1);

        // constrained random classes
        for (int k = 0; k < 20; k++) begin
            cls = int'($urandom % 8);
            fire(cls);
            wait_run();
            check_seq(cls, req_of(cls));
            check(run_mode == 1, "R9 random run", run_mode, 1);
        end

        // R10: timeout on flash stage
        check(timeout_err == 0, "R10 error clear before", timeout_err, 0);
        block_flash = 1'b1;
        fire(3);
        n = 0;
        while (!pwr_start && n < 4 * TMO) begin @(negedge clk); #2; n++; end
        check(n == TMO, "R10 timeout distance", n, TMO);
        check(timeout_err == 1, "R10 error raised", timeout_err, 1);
        block_flash = 1'b0;
        wait_run();
        check(seq_len == 5 && seq_log[1] == 1 && seq_log[2] == 2 && seq_log[3] == 3,
              "R10 restart path", seq_len, 5);
        fire(4);
        wait_run();
        check(timeout_err == 1, "R10 error sticky", timeout_err, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule